// File: doc/BRIEF.md
# Synchronous-Enable Clock Selector with Fanout

This block picks one of two incoming clocks and copies the chosen clock to a set of output pairs. Each pair has a true output and a complement output. A single enable input turns every pair on or off together. The enable does not act on the outputs directly. A register samples it on the falling edge of the chosen clock, so the outputs change between running and parked only while the clock is low. This means no output ever shows a shortened high pulse.

The block sits at the root of a small clock tree. The select input chooses the source clock. The enable input lets the tree be stopped and restarted cleanly. An active-low asynchronous reset clears the enable register, so after reset every pair is parked with the true output low and the complement output high. The select input is expected to change only while the outputs are parked.

Top module: `clkmux_fanout`

## Requirements
- R1: When `src_sel` is 0, the clock on `clk_a` is the chosen clock that drives all output pairs.
- R2: When `src_sel` is 1, the clock on `clk_b` is the chosen clock that drives all output pairs.
- R3: The internal enable state takes the value of `out_en` at each falling edge of the chosen clock, and at no other clock edge.
- R4: A true output never shows a high pulse shorter than half a period of the chosen clock, across any sequence of enable changes.
- R5: While the enable state is 0, every `q_true` bit is 0 and every `q_comp` bit is 1.
- R6: While the enable state is 1, every `q_true` bit equals the chosen clock and every `q_comp` bit is its inverse.
- R7: If `out_en` changes while the chosen clock is high, the outputs do not reflect the change until the chosen clock has gone low and then high again.
- R8: All NUM_PAIRS pairs carry identical values at all times; bit g of `q_true` and bit g of `q_comp` form pair g.
- R9: While `rst_n` is 0, the enable state is forced to 0, so the outputs are parked as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Clock source chosen when `src_sel` is 0 |
| clk_b | input | 1 | Clock source chosen when `src_sel` is 1 |
| src_sel | input | 1 | Source choice: 0 picks `clk_a`, 1 picks `clk_b` |
| out_en | input | 1 | Common enable, sampled on the falling edge of the chosen clock |
| rst_n | input | 1 | Active-low asynchronous reset of the enable state |
| q_true | output | NUM_PAIRS | True outputs, one bit per pair |
| q_comp | output | NUM_PAIRS | Complement outputs, one bit per pair |

## Verification
The properties assume that `src_sel` changes only while the enable state is 0 and never at the same instant as an edge of either clock. Without this, the multiplexer could create a runt edge, and that case is outside the block's scope. The properties also assume that `rst_n` is asserted only at start-up, because an asynchronous clear while the clock is high would cut a pulse short. Finally, they assume that `out_en` never moves on a falling edge of the chosen clock. The stimulus drives `out_en` at whole-nanosecond offsets strictly inside a clock phase. It moves `src_sel` only after several falling edges with the enable at 0, at a quarter-nanosecond offset from every clock edge. It releases reset once, before any enable is applied.

// File: rtl/clkmux_fanout_pkg.sv
package clkmux_fanout_pkg;
    // Registered state of the enable path.
    typedef struct packed {
        logic en;
    } gate_state_t;

    // Value a parked true output holds; the complement holds the inverse.
    localparam logic PARK_LEVEL = 1'b0;
endpackage

// File: rtl/clkmux_pick.sv
module clkmux_pick (
    input  logic clk_a,
    input  logic clk_b,
    input  logic src_sel,
    output logic sel_clk
);
    // Plain two-way selection; src_sel must move only while parked.
    always_comb begin
        sel_clk = src_sel ? clk_b : clk_a;
    end
endmodule

// File: rtl/clkmux_en_sync.sv
module clkmux_en_sync
    import clkmux_fanout_pkg::*;
(
    input  logic sel_clk,
    input  logic rst_n,
    input  logic out_en,
    output logic en_q
);
    gate_state_t st_d;
    gate_state_t st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = out_en;
    end

    // Falling edge: the state changes only while the chosen clock is low.
    always_ff @(negedge sel_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q = st_q.en;
endmodule

// File: rtl/clkmux_pair_drv.sv
module clkmux_pair_drv
    import clkmux_fanout_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input  logic                 sel_clk,
    input  logic                 en_q,
    output logic [NUM_PAIRS-1:0] q_true,
    output logic [NUM_PAIRS-1:0] q_comp
);
    logic gclk;

    always_comb begin
        gclk = en_q ? sel_clk : PARK_LEVEL;
    end

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        assign q_true[g] = gclk;
        assign q_comp[g] = ~gclk;
    end
endmodule

// File: rtl/clkmux_fanout.sv
module clkmux_fanout #(
    parameter int NUM_PAIRS = 4
) (
    input  logic                 clk_a,
    input  logic                 clk_b,
    input  logic                 src_sel,
    input  logic                 out_en,
    input  logic                 rst_n,
    output logic [NUM_PAIRS-1:0] q_true,
    output logic [NUM_PAIRS-1:0] q_comp
);
    logic sel_clk;
    logic en_q;

    clkmux_pick i_pick (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .src_sel (src_sel),
        .sel_clk (sel_clk)
    );

    clkmux_en_sync i_sync (
        .sel_clk (sel_clk),
        .rst_n   (rst_n),
        .out_en  (out_en),
        .en_q    (en_q)
    );

    clkmux_pair_drv #(.NUM_PAIRS(NUM_PAIRS)) i_drv (
        .sel_clk (sel_clk),
        .en_q    (en_q),
        .q_true  (q_true),
        .q_comp  (q_comp)
    );
endmodule

// File: rtl/clkmux_fanout_chk.sv
module clkmux_fanout_chk #(
    parameter int NUM_PAIRS = 4
) (
    input logic                 clk_a,
    input logic                 clk_b,
    input logic                 src_sel,
    input logic                 out_en,
    input logic                 rst_n,
    input logic                 sel_clk,
    input logic                 en_q,
    input logic [NUM_PAIRS-1:0] q_true,
    input logic [NUM_PAIRS-1:0] q_comp
);
    assert_route_a_R1: assert property (@(negedge clk_a) disable iff (!rst_n)
        (!src_sel && en_q) |-> (q_true == '1));

    assert_route_b_R2: assert property (@(negedge clk_b) disable iff (!rst_n)
        (src_sel && en_q) |-> (q_true == '1));

    assert_capture_R3: assert property (@(negedge sel_clk) disable iff (!rst_n)
        1'b1 |=> (en_q == $past(out_en)));

    // R4: output edges coincide with edges of the chosen clock.
    always @(posedge q_true[0]) begin
        if (rst_n) assert_rise_R4: assert (sel_clk);
    end
    always @(negedge q_true[0]) begin
        if (rst_n) assert_fall_R4: assert (!sel_clk);
    end

    assert_parked_R5: assert property (@(negedge sel_clk) disable iff (!rst_n)
        !en_q |-> (q_true == '0 && q_comp == '1));

    assert_running_R6: assert property (@(negedge sel_clk) disable iff (!rst_n)
        en_q |-> (q_true == '1 && q_comp == '0));

    assert_pairs_equal_R8: assert property (@(negedge sel_clk) disable iff (!rst_n)
        ($countones(q_true) == 0) || ($countones(q_true) == NUM_PAIRS));
endmodule

bind clkmux_fanout clkmux_fanout_chk #(.NUM_PAIRS(NUM_PAIRS)) i_chk (
    .clk_a   (clk_a),
    .clk_b   (clk_b),
    .src_sel (src_sel),
    .out_en  (out_en),
    .rst_n   (rst_n),
    .sel_clk (sel_clk),
    .en_q    (en_q),
    .q_true  (q_true),
    .q_comp  (q_comp)
);

// File: tb/test_clkmux_fanout.sv
`timescale 1ns/10ps
module test_clkmux_fanout;
    localparam int NP = 4;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic src_sel = 1'b0;
    logic out_en = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] q_true;
    logic [NP-1:0] q_comp;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    clkmux_fanout #(.NUM_PAIRS(NP)) i_clkmux_fanout (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .src_sel (src_sel),
        .out_en  (out_en),
        .rst_n   (rst_n),
        .q_true  (q_true),
        .q_comp  (q_comp)
    );

    // 50 MHz primary clock; second clock 28 ns period, offset by 3 ns.
    initial forever #10 clk_a = ~clk_a;
    initial begin
        #3;
        forever #14 clk_b = ~clk_b;
    end

    // Reference model: R1/R2 choice, R3 sampling on the falling edge, R9 reset.
    logic ref_clk;
    logic ref_en = 1'b0;
    assign ref_clk = src_sel ? clk_b : clk_a;
    always @(negedge ref_clk or negedge rst_n) begin
        if (!rst_n) ref_en <= 1'b0;
        else        ref_en <= out_en;
    end

    task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // Per-sample comparison every nanosecond, half a step away from any edge.
    int hi_len = 0;
    int hi_min = 10;
    logic prev_t0 = 1'b0;
    initial begin
        #0.5;
        forever begin
            logic [NP-1:0] exp_t;
            exp_t = {NP{ref_clk & ref_en}};
            if (!rst_n)      check("R9 reset parks pairs", q_true, '0);
            else if (ref_en) check(src_sel ? "R2,R6 running true" : "R1,R6 running true", q_true, exp_t);
            else             check("R5 parked true", q_true, exp_t);
            check("R8 complement of every pair", q_comp, ~exp_t);
            // R4: high pulse length in 1 ns samples
            if (q_true[0] && !prev_t0) begin
                hi_len = 1;
                hi_min = src_sel ? 14 : 10;
            end else if (q_true[0]) begin
                hi_len++;
            end else if (prev_t0) begin
                n_tests++;
                if (hi_len < hi_min) begin
                    n_fail++;
                    $display("FAIL R4 short pulse at %0t: actual %0d ns expected >= %0d ns",
                             $time, hi_len, hi_min);
                end
            end
            prev_t0 = q_true[0];
            #1;
        end
    end

    task automatic random_toggles(input int count);
        for (int i = 0; i < count; i++) begin
            int waits;
            int off;
            waits = 1 + int'($urandom_range(3));
            for (int w = 0; w < waits; w++) @(posedge ref_clk);
            off = 1 + int'($urandom_range(src_sel ? 12 : 8));
            #(off);
            out_en = $urandom_range(1);
        end
    endtask

    task automatic switch_source(input logic to_b);
        out_en = 1'b0;
        for (int w = 0; w < 3; w++) @(negedge ref_clk);
        @(posedge clk_a);
        #1.25;
        src_sel = to_b;
        #40;
    endtask

    // R7: enable raised while the clock is high waits for a fall then a rise.
    task automatic directed_delay(input string tag);
        @(posedge ref_clk);
        #2;
        out_en = 1'b1;
        #2.5;
        check({"R7 still parked in raising phase ", tag}, q_true, '0);
        @(negedge ref_clk);
        #3.5;
        check({"R3 captured but clock low ", tag}, q_true, '0);
        @(posedge ref_clk);
        #1.5;
        check({"R7 running after fall then rise ", tag}, q_true, '1);
        // lowering while high: this high phase stays whole
        #1;
        out_en = 1'b0;
        #1.5;
        check({"R4 high phase kept after disable ", tag}, q_true, '1);
        @(negedge ref_clk);
        @(posedge ref_clk);
        #1.5;
        check({"R5 parked after disable ", tag}, q_true, '0);
    endtask

    initial begin
        out_en = 1'b1;
        #2.5;
        check("R9 reset true low", q_true, '0);
        check("R9 reset complement high", q_comp, '1);
        #30;
        check("R9 reset ignores clocks with enable high", q_true, '0);
        out_en = 1'b0;
        @(posedge clk_a);
        #2;
        rst_n = 1'b1;
        #40;
        directed_delay("clk_a");
        random_toggles(400);
        switch_source(1'b1);
        directed_delay("clk_b");
        random_toggles(400);
        switch_source(1'b0);
        random_toggles(200);
        out_en = 1'b0;
        #100;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule